// File: doc/BRIEF.md
# Ring-Oscillator Logic Speed Monitor

This block gauges how fast the surrounding silicon is running. Each of several identical channels receives the edge signal of a free-running ring oscillator. It counts that oscillator's rising edges during a measurement window whose length is set by a fixed-rate reference clock. The oscillator frequency follows core voltage, process speed and temperature, so the count per window is a direct speed figure.

One shared sequencer, made of a free-running phase counter and a comparator, drives every channel through the same cycle. First comes a counting phase. A hold phase follows, during which the oscillator counters stop. Then a single latch cycle copies each count into its result register. A clear phase ends the cycle and zeroes the counters before the next window.

The latched results stay constant between updates. A one-cycle strobe marks every update, so an external capture can take exactly one sample per new result. Counts saturate at the top of the result width instead of wrapping.

Top module: `ringspd_mon`

## Requirements
- R1: While reset is asserted and until the first complete window has been latched, every channel result reads zero and `upd_stb` stays low.
- R2: The sequence repeats every `PERIOD` reference cycles. With the default parameters, the first `upd_stb` is seen in the 68th reference cycle after reset release. After that, `upd_stb` is high for exactly one cycle in every 80.
- R3: The latch point falls `LATCH_GAP` reference cycles after the count enable drops. The clear phase starts one cycle after the latch point and ends when the next enable begins. Enable and clear are never high together.
- R4: Each channel's result equals the number of rising edges of its oscillator input during the `WIN_CYC`-cycle window, within plus or minus one.
- R5: A channel whose edge count in a window reaches or exceeds 255 reads exactly 255, the 8-bit maximum. It never wraps.
- R6: Result values change only in the cycle in which `upd_stb` is high. All channels update in that same cycle.
- R7: A channel whose oscillator input never toggles reads zero.
- R8: Channels are independent. A change in one oscillator's rate does not alter any other channel's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fixed-rate reference clock that sets the window |
| rst_n | input | 1 | Active-low asynchronous reset for all domains |
| osc_in | input | NUM_CH | One ring-oscillator edge signal per channel |
| cnt_flat | output | NUM_CH*CNT_W | Latched counts; channel i occupies bits [i*CNT_W +: CNT_W] |
| upd_stb | output | 1 | One-cycle pulse in the cycle the results change |

## Verification
Several internal faults reach the ports within one sequence period of 80 reference cycles:
- A sequencer decode that is misplaced shifts the cycle of the first strobe after reset, or changes the spacing between strobes.
- A clear that comes too late, or never, shows up in the next latched value as a count near double the expected one.
- A latch taken before the counter has stopped shows up as a count that falls short.
- Wrapping in place of saturation shows on the first window after a fast oscillator is applied, where the result reads far below 255.
- A result register loaded outside the latch point shows as a value that changes between strobes.

// File: rtl/ringspd_pkg.sv
package ringspd_pkg;
   typedef enum logic [1:0] {
      PH_RUN   = 2'd0,
      PH_HOLD  = 2'd1,
      PH_LATCH = 2'd2,
      PH_CLEAR = 2'd3
   } phase_e;
endpackage

// File: rtl/ringspd_seq.sv
module ringspd_seq
   import ringspd_pkg::*;
#(
   parameter int WIN_CYC   = 64,
   parameter int LATCH_GAP = 2,
   parameter int PERIOD    = 80
) (
   input  logic clk_ref,
   input  logic rst_n,
   output logic run_en,
   output logic latch_p,
   output logic clr_lvl
);
   localparam int PW     = $clog2(PERIOD);
   localparam int LAT_PT = WIN_CYC + LATCH_GAP;

   if (PERIOD < LAT_PT + 3) begin : g_bad_period
      $error("PERIOD too short for window, gap and clear");
   end
   if (LATCH_GAP < 1) begin : g_bad_gap
      $error("LATCH_GAP must be at least 1");
   end

   logic [PW-1:0] ph_cnt;
   phase_e        ph_dec;

   always_comb begin
      if (ph_cnt < PW'(WIN_CYC))      ph_dec = PH_RUN;
      else if (ph_cnt < PW'(LAT_PT))  ph_dec = PH_HOLD;
      else if (ph_cnt == PW'(LAT_PT)) ph_dec = PH_LATCH;
      else                            ph_dec = PH_CLEAR;
   end

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         ph_cnt  <= '0;
         run_en  <= 1'b0;
         latch_p <= 1'b0;
         clr_lvl <= 1'b0;
      end else begin
         ph_cnt  <= (ph_cnt == PW'(PERIOD - 1)) ? '0 : ph_cnt + 1'b1;
         run_en  <= (ph_dec == PH_RUN);
         latch_p <= (ph_dec == PH_LATCH);
         clr_lvl <= (ph_dec == PH_CLEAR);
      end
   end

   AST_EN_CLR_EXCL: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !(run_en && clr_lvl)); // R3
   AST_LATCH_AFTER_STOP: assert property (@(posedge clk_ref) disable iff (!rst_n)
      latch_p |-> !run_en && !$past(run_en)); // R3
   AST_CLEAR_AFTER_LATCH: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(clr_lvl) |-> $past(latch_p)); // R3
endmodule

// File: rtl/ringspd_chan.sv
module ringspd_chan #(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit SATURATE    = 1'b1
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             osc_clk,
   input  logic             run_en,
   input  logic             clr_lvl,
   input  logic             latch_p,
   output logic [CNT_W-1:0] res_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] en_sy;
   logic [SYNC_STAGES-1:0] clr_sy;
   logic [CNT_W-1:0]       osc_cnt;
   logic [CNT_W-1:0]       cnt_nxt;
   logic                   en_s;
   logic                   clr_s;

   assign en_s  = en_sy[SYNC_STAGES-1];
   assign clr_s = clr_sy[SYNC_STAGES-1];

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         en_sy  <= '0;
         clr_sy <= '0;
      end else begin
         en_sy  <= {en_sy[SYNC_STAGES-2:0], run_en};
         clr_sy <= {clr_sy[SYNC_STAGES-2:0], clr_lvl};
      end
   end

   if (SATURATE) begin : g_sat
      assign cnt_nxt = (osc_cnt == CNT_MAX) ? osc_cnt : osc_cnt + 1'b1;
   end else begin : g_wrap
      assign cnt_nxt = osc_cnt + 1'b1;
   end

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n)     osc_cnt <= '0;
      else if (clr_s) osc_cnt <= '0;
      else if (en_s)  osc_cnt <= cnt_nxt;
   end

   // The counter has been stopped for LATCH_GAP reference cycles here,
   // so the multi-bit value is stable when sampled.
   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n)       res_q <= '0;
      else if (latch_p) res_q <= osc_cnt;
   end

   if (SATURATE) begin : g_sat_chk
      AST_NO_OVERFLOW: assert property (@(posedge osc_clk) disable iff (!rst_n)
         (osc_cnt == CNT_MAX) |=> (osc_cnt == CNT_MAX) || (osc_cnt == '0)); // R5
   end
endmodule

// File: rtl/ringspd_mon.sv
module ringspd_mon #(
   parameter int NUM_CH      = 12,
   parameter int CNT_W       = 8,
   parameter int WIN_CYC     = 64,
   parameter int LATCH_GAP   = 2,
   parameter int PERIOD      = 80,
   parameter int SYNC_STAGES = 2,
   parameter bit SATURATE    = 1'b1
) (
   input  logic                    clk_ref,
   input  logic                    rst_n,
   input  logic [NUM_CH-1:0]       osc_in,
   output logic [NUM_CH*CNT_W-1:0] cnt_flat,
   output logic                    upd_stb
);
   if (NUM_CH < 1 || CNT_W < 2) begin : g_bad_dims
      $error("NUM_CH and CNT_W out of range");
   end

   logic run_en;
   logic latch_p;
   logic clr_lvl;

   ringspd_seq #(
      .WIN_CYC  (WIN_CYC),
      .LATCH_GAP(LATCH_GAP),
      .PERIOD   (PERIOD)
   ) seq_i (
      .clk_ref(clk_ref),
      .rst_n  (rst_n),
      .run_en (run_en),
      .latch_p(latch_p),
      .clr_lvl(clr_lvl)
   );

   for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
      ringspd_chan #(
         .CNT_W      (CNT_W),
         .SYNC_STAGES(SYNC_STAGES),
         .SATURATE   (SATURATE)
      ) chan_i (
         .clk_ref(clk_ref),
         .rst_n  (rst_n),
         .osc_clk(osc_in[gi]),
         .run_en (run_en),
         .clr_lvl(clr_lvl),
         .latch_p(latch_p),
         .res_q  (cnt_flat[gi*CNT_W +: CNT_W])
      );
   end

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) upd_stb <= 1'b0;
      else        upd_stb <= latch_p;
   end

   AST_HOLD_BETWEEN: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !$stable(cnt_flat) |-> upd_stb); // R6
   AST_STB_PULSE: assert property (@(posedge clk_ref) disable iff (!rst_n)
      upd_stb |=> !upd_stb); // R2
endmodule

// File: tb/ringspd_mon_tb_top.sv
`timescale 1ns/1ps
module ringspd_mon_tb_top;
   localparam int NCH  = 12;
   localparam int CW   = 8;
   localparam int WIN  = 64;
   localparam int LG   = 2;
   localparam int PER  = 80;
   localparam int WIN_PS = WIN * 4000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NCH-1:0]    osc_v;
   logic              osc_u [NCH];
   int                per_ps [NCH];
   logic [NCH*CW-1:0] cnt_flat;
   logic              upd_stb;
   int                n_chk = 0;
   int                n_err = 0;

   always #2 clk = ~clk;

   for (genvar g = 0; g < NCH; g++) begin : g_osc
      initial begin
         osc_u[g] = 1'b0;
         forever begin
            if (per_ps[g] == 0) begin
               osc_u[g] = 1'b0;
               #0.1;
            end else begin
               #(per_ps[g] / 2000.0);
               osc_u[g] = ~osc_u[g];
            end
         end
      end
   end

   always_comb for (int k = 0; k < NCH; k++) osc_v[k] = osc_u[k];

   ringspd_mon dut_i (
      .clk_ref (clk),
      .rst_n   (rst_n),
      .osc_in  (osc_v),
      .cnt_flat(cnt_flat),
      .upd_stb (upd_stb)
   );

   function automatic int ch_val(int i);
      return int'(cnt_flat[i*CW +: CW]);
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_stb();
      do @(negedge clk); while (!upd_stb);
   endtask

   task automatic check_counts(string req);
      for (int i = 0; i < NCH; i++) begin
         int n = (per_ps[i] == 0) ? 0 : WIN_PS / per_ps[i];
         int a = ch_val(i);
         if (per_ps[i] == 0)  chk(a == 0, req, a, 0);
         else if (n >= 256)   chk(a == 255, req, a, 255);
         else                 chk(a >= n - 1 && a <= n + 1 && a <= 255, req, a, n);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // R1, R2: reset state, then first strobe position
   task automatic t_reset_first();
      int cyc = 0;
      bit quiet = 1'b1;
      do_reset();
      while (!upd_stb && cyc < 200) begin
         @(negedge clk);
         cyc++;
         if (!upd_stb && cnt_flat != '0) quiet = 1'b0;
      end
      chk(quiet, "R1 zero before first update", int'(quiet), 1);
      chk(cyc == WIN + LG + 2, "R2 first strobe cycle", cyc, WIN + LG + 2);
      check_counts("R4 first window");
   endtask

   // R2, R6: strobe spacing, single-cycle pulse, results held
   task automatic t_period_hold();
      logic [NCH*CW-1:0] snap;
      int cyc = 0;
      bit held = 1'b1;
      snap = cnt_flat;
      @(negedge clk);
      cyc++;
      chk(!upd_stb, "R2 strobe one cycle", int'(upd_stb), 0);
      while (!upd_stb) begin
         if (cnt_flat != snap) held = 1'b0;
         @(negedge clk);
         cyc++;
      end
      chk(cyc == PER, "R2 strobe spacing", cyc, PER);
      chk(held, "R6 results held between strobes", int'(held), 1);
      check_counts("R4 steady window");
   endtask

   // R4, R8: new rate pattern across channels
   task automatic t_pattern();
      for (int i = 0; i < NCH; i++) per_ps[i] = 1560 - 20 * i;
      wait_stb();
      wait_stb();
      check_counts("R8 reordered rates");
   endtask

   // R5, R8: one channel far too fast saturates, others unaffected
   task automatic t_saturate();
      per_ps[0] = 800;
      per_ps[5] = 1000;
      wait_stb();
      wait_stb();
      chk(ch_val(0) == 255, "R5 saturate ch0", ch_val(0), 255);
      chk(ch_val(5) == 255, "R5 saturate ch5", ch_val(5), 255);
      check_counts("R8 neighbours of saturated");
   endtask

   // R7: silent oscillator reads zero
   task automatic t_stopped();
      for (int i = 0; i < NCH; i++) per_ps[i] = 1340 + 20 * i;
      per_ps[11] = 0;
      do_reset();
      wait_stb();
      chk(ch_val(11) == 0, "R7 silent channel", ch_val(11), 0);
      check_counts("R7 others with silent channel");
      per_ps[11] = 1500;
      wait_stb();
      wait_stb();
      check_counts("R8 channel restarted");
   endtask

   initial begin
      for (int i = 0; i < NCH; i++) per_ps[i] = 1340 + 20 * i;
      #1;
      chk(upd_stb == 1'b0, "R1 strobe low in reset", int'(upd_stb), 0);
      chk(cnt_flat == '0, "R1 results zero in reset", int'(cnt_flat[CW-1:0]), 0);
      t_reset_first();
      t_period_hold();
      t_pattern();
      t_saturate();
      t_stopped();
      t_period_hold();
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule